// File: doc/BRIEF.md
# Hardware Stack Pointer Unit

This block owns the stack pointer and a 16-bit index register inside a small 8/16-bit CPU datapath. On request it performs byte or word pushes and pulls. For each byte moved it drives a byte address and a read or write strobe toward memory. It also loads the stack pointer from an immediate value and copies values in either direction between the stack pointer and the index register. Instruction decode, interrupt stacking and flags are handled elsewhere. The block only does pointer arithmetic and address generation.

The stack grows downward, and the pointer always names the most recently occupied byte. A push therefore decrements first and then writes. A pull reads first and then increments. A word operation takes two byte cycles. During the second cycle a busy flag is raised, and any request presented in that cycle is discarded.

Top module: `sp_engine`

## Requirements
- R1: After reset, `sp` and `ix` read 0x0000, and `busy`, `pull_valid`, `mem_we` and `mem_re` are all low.
- R2: An accepted byte push (`req_op`=1) drives `mem_we` high in the same cycle. It writes `req_data[7:0]` at address `sp`−1, and `sp` takes that address at the next edge.
- R3: An accepted byte pull (`req_op`=3) drives `mem_re` high with address `sp` in the same cycle. After the edge, `pull_data` holds {0x00, byte read} with `pull_valid` high for one cycle, and `sp` has grown by one.
- R4: A word push (`req_op`=2) writes `req_data[7:0]` at `sp`−1 in its first cycle. It writes `req_data[15:8]` at `sp`−2 in the following cycle, with `busy` high during that cycle. It ends with `sp` reduced by two, pointing at the high byte.
- R5: A word pull (`req_op`=4) reads the high byte at `sp` first and the low byte at `sp`+1 in the next cycle, with `busy` high during that cycle. It then presents {high, low} on `pull_data` with `pull_valid`, and leaves `sp` increased by two.
- R6: Loading the stack pointer (`req_op`=5) sets `sp` to `req_data`, so the first byte pushed afterwards lands one address below the loaded value.
- R7: `req_op`=6 copies `sp` into `ix` unchanged, and `req_op`=7 copies `ix` into `sp` unchanged.
- R8: A request presented while `busy` is high has no effect on `sp`, on `ix` or on the memory strobes. `busy` never stays high for two cycles in a row.
- R9: Stack pointer arithmetic wraps modulo 2^16. A push from 0x0000 writes at 0xFFFF, and a pull from 0xFFFF continues at 0x0000.
- R10: `mem_we` and `mem_re` are never high together. Both are low when no request is accepted and no word operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 none, 1 push byte, 2 push word, 3 pull byte, 4 pull word, 5 load SP, 6 SP to index, 7 index to SP |
| req_data | input | 16 | Push data or load value |
| mem_rdata | input | 8 | Byte returned from memory at `mem_addr` |
| mem_addr | output | 16 | Byte address of the current access |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Byte to write |
| sp | output | 16 | Stack pointer |
| ix | output | 16 | Index register |
| busy | output | 1 | Second cycle of a word operation |
| pull_data | output | 16 | Result of the last pull |
| pull_valid | output | 1 | One-cycle pulse when `pull_data` is new |

## Verification
The bench sweeps load values that sit at and just next to the address-space edges. A unit that wraps wrongly, or that lands its first push on the loaded address instead of one below, writes to the wrong cell, and the pulled data comes back wrong. During every second cycle of a word operation the bench presents a conflicting request. A unit that accepts it corrupts `sp` or issues an extra strobe. Word pulls check byte order, which catches swapped halves or a reversed access sequence. Transfers are checked against the exact source value, which exposes any hidden ±1 correction.

// File: rtl/sp_engine.sv
module sp_engine #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_data,
  input  logic [BW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [BW-1:0] mem_wdata,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] ix,
  output logic          busy,
  output logic [2*BW-1:0] pull_data,
  output logic          pull_valid
);
  localparam int WW = 2 * BW;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PUSHB  = 3'd1,
    OP_PUSHW  = 3'd2,
    OP_PULLB  = 3'd3,
    OP_PULLW  = 3'd4,
    OP_LDSP   = 3'd5,
    OP_SP2IX  = 3'd6,
    OP_IX2SP  = 3'd7
  } op_e;

  op_e           op;
  logic          take, pend_pull, push_now, pull_now;
  logic [BW-1:0] hold;
  logic [AW-1:0] sp_dn, sp_up;

  assign op    = op_e'(req_op);
  assign take  = req_valid && !busy;
  assign sp_dn = sp - 1'b1;
  assign sp_up = sp + 1'b1;

  assign push_now = busy ? !pend_pull : take && (op == OP_PUSHB || op == OP_PUSHW);
  assign pull_now = busy ?  pend_pull : take && (op == OP_PULLB || op == OP_PULLW);

  assign mem_we    = push_now;
  assign mem_re    = pull_now;
  assign mem_addr  = push_now ? sp_dn : sp;
  assign mem_wdata = busy ? hold : req_data[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp         <= '0;
      ix         <= '0;
      busy       <= 1'b0;
      pend_pull  <= 1'b0;
      hold       <= '0;
      pull_data  <= '0;
      pull_valid <= 1'b0;
    end else begin
      pull_valid <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        if (pend_pull) begin
          sp         <= sp_up;
          pull_data  <= {hold, mem_rdata};
          pull_valid <= 1'b1;
        end else begin
          sp <= sp_dn;
        end
      end else if (take) begin
        unique case (op)
          OP_PUSHB: sp <= sp_dn;
          OP_PUSHW: begin
            sp        <= sp_dn;
            busy      <= 1'b1;
            pend_pull <= 1'b0;
            hold      <= req_data[WW-1:BW];
          end
          OP_PULLB: begin
            sp         <= sp_up;
            pull_data  <= {{BW{1'b0}}, mem_rdata};
            pull_valid <= 1'b1;
          end
          OP_PULLW: begin
            sp        <= sp_up;
            busy      <= 1'b1;
            pend_pull <= 1'b1;
            hold      <= mem_rdata;
          end
          OP_LDSP:  sp <= req_data;
          OP_SP2IX: ix <= sp;
          OP_IX2SP: sp <= ix;
          default: ;
        endcase
      end
    end
  end

  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_PUSHB |=> sp == AW'($past(sp) - 1'b1)); // R2
  AST_PULL_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_PULLB |=> sp == AW'($past(sp) + 1'b1) && pull_valid); // R3
  AST_WORD_HIGH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_PUSHW |=> busy && mem_we && mem_wdata == $past(req_data[WW-1:BW])); // R4
  AST_WORD_PULL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_PULLW |=> busy && mem_re && !mem_we); // R5
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_LDSP |=> sp == $past(req_data)); // R6
  AST_SP2IX_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_SP2IX |=> ix == $past(sp) && $stable(sp)); // R7
  AST_IX2SP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_IX2SP |=> sp == $past(ix) && $stable(ix)); // R7
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && $stable(ix)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !req_valid |-> !mem_we && !mem_re); // R10
endmodule

// File: tb/sp_engine_tb.sv
`timescale 1ns/1ps
module sp_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_data = 16'h0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, sp, ix, pull_data;
  logic        mem_we, mem_re, busy, pull_valid;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] m_sp = 16'h0;
  logic [15:0] m_ix = 16'h0;
  logic [7:0]  mem [256];

  always #2 clk = ~clk;

  sp_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .sp(sp),
    .ix(ix), .busy(busy), .pull_data(pull_data), .pull_valid(pull_valid)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d;
  endtask

  task automatic close_op();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0;
  endtask

  task automatic load_sp(input logic [15:0] v);
    drive(3'd5, v);
    close_op();
    m_sp = v;
    chk("R6 load", sp, v);
  endtask

  task automatic push_b(input logic [7:0] d);
    drive(3'd1, {8'h00, d});
    #1;
    chk("R2 we", {mem_we, mem_re}, 2'b10);
    chk("R2 addr", mem_addr, 16'(m_sp - 1));
    chk("R2 data", mem_wdata, d);
    close_op();
    m_sp = m_sp - 1;
    chk("R2 sp", sp, m_sp);
  endtask

  task automatic push_w(input logic [15:0] w);
    drive(3'd2, w);
    #1;
    chk("R4 first", {busy, mem_we, mem_addr, mem_wdata}, {1'b0, 1'b1, 16'(m_sp - 1), w[7:0]});
    @(posedge clk);
    #1;
    req_op = 3'd5; req_data = 16'hDEAD;
    #0.5;
    chk("R8 busy", busy, 1'b1);
    chk("R4 second", {mem_we, mem_re, mem_addr, mem_wdata}, {2'b10, 16'(m_sp - 2), w[15:8]});
    close_op();
    m_sp = m_sp - 2;
    chk("R4 sp", sp, m_sp);
    chk("R8 done", busy, 1'b0);
  endtask

  task automatic pull_b(input logic [7:0] e);
    drive(3'd3, 16'h0);
    #1;
    chk("R3 strobe", {mem_we, mem_re, mem_addr}, {2'b01, m_sp});
    close_op();
    m_sp = m_sp + 1;
    chk("R3 data", {pull_valid, pull_data}, {1'b1, 8'h00, e});
    chk("R3 sp", sp, m_sp);
  endtask

  task automatic pull_w(input logic [15:0] e);
    drive(3'd4, 16'h0);
    #1;
    chk("R5 first", {busy, mem_we, mem_re, mem_addr}, {3'b001, m_sp});
    @(posedge clk);
    #1;
    req_op = 3'd1; req_data = 16'h0055;
    #0.5;
    chk("R8 no write", {busy, mem_we, mem_re, mem_addr}, {3'b101, 16'(m_sp + 1)});
    close_op();
    m_sp = m_sp + 2;
    chk("R5 data", {pull_valid, pull_data}, {1'b1, e});
    chk("R5 sp", sp, m_sp);
  endtask

  task automatic sp_to_ix();
    drive(3'd6, 16'hFFFF);
    close_op();
    m_ix = m_sp;
    chk("R7 sp->ix", {ix, sp}, {m_ix, m_sp});
  endtask

  task automatic ix_to_sp();
    drive(3'd7, 16'hFFFF);
    close_op();
    m_sp = m_ix;
    chk("R7 ix->sp", {sp, ix}, {m_sp, m_ix});
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h8000, 16'hFFFF, 16'h1235, 16'h0100};
    foreach (mem[i]) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 regs", {sp, ix}, 32'h0);
    chk("R1 flags", {busy, pull_valid, mem_we, mem_re}, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [7:0]  a, b;
      logic [15:0] w;
      a = 8'(8'h11 * (i + 1));
      b = ~a;
      w = {8'(8'h3C + i), 8'(8'hC3 - i)};
      load_sp(vals[i]);
      sp_to_ix();
      chk("R7 exact", ix, vals[i]);
      push_b(a);
      push_w(w);
      push_b(b);
      chk("R6 depth", sp, 16'(vals[i] - 4));
      pull_b(b);
      pull_w(w);
      pull_b(a);
      chk("R6 return", sp, vals[i]);
    end

    load_sp(16'h0000);
    push_b(8'hA5);
    chk("R9 wrap down", sp, 16'hFFFF);
    pull_b(8'hA5);
    chk("R9 wrap up", sp, 16'h0000);
    load_sp(16'h0001);
    push_w(16'hC33C);
    chk("R9 word down", sp, 16'hFFFF);
    pull_w(16'hC33C);
    chk("R9 word up", sp, 16'h0001);

    load_sp(16'h4000);
    sp_to_ix();
    load_sp(16'h1111);
    ix_to_sp();
    chk("R7 restore", sp, 16'h4000);
    push_b(8'h7E);
    pull_b(8'h7E);

    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R10 idle", {mem_we, mem_re, pull_valid, busy}, 4'b0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule